// File: doc/BRIEF.md
# Byte-Serial CRC-32 / CRC-32C Update Unit

This unit advances a 32-bit CRC accumulator over one to eight data bytes held in a 64-bit operand. The polynomial is chosen for each operation: the common Ethernet/zip CRC-32 or the Castagnoli CRC-32C. A one-cycle start pulse captures four inputs together: the accumulator seed, the data word, a byte count and the polynomial select. The unit then consumes one byte per clock, lowest byte first, and raises a one-cycle done pulse once the new accumulator value is ready on its output.

The arithmetic is the bit-reflected form. Each byte is XORed into the low eight bits of the accumulator, followed by eight shift-right steps that fold in the reflected polynomial constant. No inversion is applied at entry or exit. Software adds any one's-complement it wants, so a long message can be split into several operations whose results are chained.

The controller has three named states:
- `ST_IDLE` waits for start. On start it loads the operands and takes transition IDLE->RUN.
- `ST_RUN` folds one byte per cycle. After the last byte it takes transition RUN->DONE.
- `ST_DONE` asserts done for a single cycle, then takes transition DONE->IDLE unconditionally.

Top module: `crc_byte_engine`

## Requirements
- R1: After reset, busy and done are 0 and crc_out is 0.
- R2: With poly_sel = 0 the update uses the reflected CRC-32 constant 0xEDB88320. Seed 0 with the single byte 0x01 yields 0x77073096.
- R3: With poly_sel = 1 the update uses the reflected CRC-32C constant 0x82F63B78. Seed 0 with the single byte 0x01 yields 0xF26B8303.
- R4: Bytes are consumed least significant first: data_in[7:0] first, then data_in[15:8], and so on.
- R5: nbytes values 1, 2, 4 and 8 select that many bytes. Every other 4-bit value, including 0, selects 8 bytes.
- R6: Operand bytes above the selected count have no effect on the result.
- R7: Only acc_in[31:0] seeds the accumulator. Bits 63:32 of acc_in have no effect.
- R8: No inversion is applied. A result fed back as the seed of a later operation gives the same value as one long pass. With outside pre- and post-inversion, "123456789" gives 0xCBF43926 for CRC-32 and 0xE3069283 for CRC-32C.
- R9: If start is accepted at clock edge E0, done is high for exactly the one cycle that follows edge E(n), where n is the effective byte count. crc_out then holds the result. busy is high from E0 until that done cycle ends, and low in the following cycle.
- R10: start is ignored while busy is high. The running operation completes with its own operands.
- R11: Once the operation ends, crc_out holds its value until the next accepted start, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when not busy) |
| poly_sel | input | 1 | 0 = CRC-32, 1 = CRC-32C |
| acc_in | input | 64 | Accumulator seed; low 32 bits used |
| data_in | input | 64 | Up to eight data bytes, little-endian |
| nbytes | input | 4 | Byte count (1, 2, 4, 8; others mean 8) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| crc_out | output | 32 | Accumulator value / result |

## Verification
The result is due a fixed number of cycles after the start edge: exactly the effective byte count. An illegal count therefore has to show an eight-cycle wait. The bench raises start between clock edges and then counts falling edges until done is seen. It compares that count with the effective byte count, reads crc_out in the same half-cycle, and checks one cycle later that done and busy have dropped. For the ignored-start and hold cases it keeps sampling at falling edges across the whole window in which a wrong design would have changed the output.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;

    localparam logic [CRC_W-1:0] POLY_REFL_IEEE = 32'hEDB88320;
    localparam logic [CRC_W-1:0] POLY_REFL_CAST = 32'h82F63B78;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } crc_state_e;

    typedef enum logic {
        POLY_IEEE = 1'b0,
        POLY_CAST = 1'b1
    } crc_poly_e;
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step
    import crc_pkg::*;
#(
    parameter int W  = CRC_W,
    parameter int BW = BYTE_W
) (
    input  logic [W-1:0]  acc,
    input  logic [BW-1:0] din,
    input  logic [W-1:0]  poly,
    output logic [W-1:0]  nxt
);
    logic [W-1:0] stage [0:BW];

    assign stage[0] = acc ^ {{(W-BW){1'b0}}, din};

    // one reflected shift per data bit
    for (genvar i = 0; i < BW; i++) begin : g_bit
        assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ poly)
                                        :  (stage[i] >> 1);
    end

    assign nxt = stage[BW];
endmodule

// File: rtl/crc_len_decode.sv
module crc_len_decode #(
    parameter int CNT_W     = 4,
    parameter int MAX_BYTES = 8,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic [CNT_W-1:0] raw,
    output logic [LEN_W-1:0] len
);
    logic legal;

    always_comb begin
        legal = (raw != '0)
             && ((raw & (raw - CNT_W'(1))) == '0)
             && (raw <= CNT_W'(MAX_BYTES));
        len = legal ? LEN_W'(raw) : LEN_W'(MAX_BYTES);
    end
endmodule

// File: rtl/crc_ctrl.sv
module crc_ctrl
    import crc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last_byte,
    output logic busy,
    output logic done,
    output logic load,
    output logic advance
);
    crc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_RUN;
            ST_RUN:  if (last_byte) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        load    = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE: load    = start;
            ST_RUN:  begin busy = 1'b1; advance = 1'b1; end
            ST_DONE: begin busy = 1'b1; done = 1'b1; end
            default: ;
        endcase
    end

    // R9: done is a single-cycle pulse followed by idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10: a start seen while busy never produces a load
    p_no_load_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |-> !load);
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
    import crc_pkg::*;
#(
    parameter int ACC_IN_W  = 64,
    parameter int DATA_W    = 64,
    parameter int CNT_W     = 4,
    localparam int MAX_BYTES = DATA_W / BYTE_W,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                poly_sel,
    input  logic [ACC_IN_W-1:0] acc_in,
    input  logic [DATA_W-1:0]   data_in,
    input  logic [CNT_W-1:0]    nbytes,
    output logic                busy,
    output logic                done,
    output logic [CRC_W-1:0]    crc_out
);
    logic [CRC_W-1:0]  acc_q;
    logic [DATA_W-1:0] data_q;
    logic [LEN_W-1:0]  left_q;
    crc_poly_e         poly_q;

    logic [LEN_W-1:0]  len_dec;
    logic [CRC_W-1:0]  acc_nxt;
    logic [CRC_W-1:0]  poly_const;
    logic              load, advance, last_byte;
    logic              unused_acc_hi;

    assign unused_acc_hi = ^acc_in[ACC_IN_W-1:CRC_W];

    crc_len_decode #(.CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) u_len (
        .raw (nbytes),
        .len (len_dec)
    );

    crc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .last_byte (last_byte),
        .busy      (busy),
        .done      (done),
        .load      (load),
        .advance   (advance)
    );

    assign poly_const = (poly_q == POLY_CAST) ? POLY_REFL_CAST : POLY_REFL_IEEE;

    crc_byte_step #(.W(CRC_W), .BW(BYTE_W)) u_step (
        .acc  (acc_q),
        .din  (data_q[BYTE_W-1:0]),
        .poly (poly_const),
        .nxt  (acc_nxt)
    );

    assign last_byte = (left_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            data_q <= '0;
            left_q <= '0;
            poly_q <= POLY_IEEE;
        end else if (load) begin
            acc_q  <= acc_in[CRC_W-1:0];
            data_q <= data_in;
            left_q <= len_dec;
            poly_q <= crc_poly_e'(poly_sel);
        end else if (advance) begin
            acc_q  <= acc_nxt;
            data_q <= data_q >> BYTE_W;
            left_q <= left_q - LEN_W'(1);
        end
    end

    assign crc_out = acc_q;

    // R5: every accepted operation starts with a power-of-two byte count
    p_len_pow2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ($countones(left_q) == 1));

    // R9: one byte retired per running cycle
    p_one_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (left_q == $past(left_q) - LEN_W'(1)));

    // R10: start during an operation leaves the captured polynomial alone
    p_keep_poly_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(poly_q));

    // R11: idle without start keeps the result
    p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(crc_out));
endmodule

// File: tb/crc_byte_engine_test.sv
module crc_byte_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        poly_sel = 1'b0;
    logic [63:0] acc_in = '0;
    logic [63:0] data_in = '0;
    logic [3:0]  nbytes = 4'd1;
    logic        busy, done;
    logic [31:0] crc_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    crc_byte_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .poly_sel(poly_sel),
        .acc_in(acc_in), .data_in(data_in), .nbytes(nbytes),
        .busy(busy), .done(done), .crc_out(crc_out)
    );

    localparam int NV = 10;
    localparam logic        V_POLY [NV] = '{0, 1, 0, 0, 0, 0, 0, 0, 0, 1};
    localparam logic [63:0] V_ACC  [NV] = '{64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
                                            64'h0, 64'h0, 64'h0,
                                            64'hDEADBEEF_00000000, 64'h0};
    localparam logic [63:0] V_DATA [NV] = '{64'h01, 64'h01, 64'h0100,
                                            64'h0100_0000,
                                            64'h0100_0000_0000_0000,
                                            64'h0100_0000_0000_0000,
                                            64'h0100_0000_0000_0000,
                                            64'hAAAA_AAAA_AAAA_AA01,
                                            64'h01,
                                            64'h0100_0000_0000_0000};
    localparam logic [3:0]  V_CNT  [NV] = '{1, 1, 2, 4, 8, 3, 0, 1, 1, 15};
    localparam logic [31:0] V_EXP  [NV] = '{32'h77073096, 32'hF26B8303,
                                            32'h77073096, 32'h77073096,
                                            32'h77073096, 32'h77073096,
                                            32'h77073096, 32'h77073096,
                                            32'h77073096, 32'hF26B8303};
    // R2, R3, R4, R5 (4), R5 (8), R5 (3->8), R5 (0->8), R6, R7, R5 (15->8)
    localparam int          V_REQ  [NV] = '{2, 3, 4, 5, 5, 5, 5, 6, 7, 5};

    task automatic check(input bit ok, input int req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // R9: latency, single-cycle done and busy release checked on every op
    task automatic run_op(input logic ps, input logic [63:0] acc,
                          input logic [63:0] dat, input logic [3:0] n,
                          input int req, output logic [31:0] res);
        int eff;
        int waited;
        eff = (n == 1 || n == 2 || n == 4 || n == 8) ? int'(n) : 8;
        @(negedge clk);
        poly_sel = ps; acc_in = acc; data_in = dat; nbytes = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check(waited == eff, 9, "done latency", 64'(waited), 64'(eff));
        res = crc_out;
        check(busy == 1'b1, 9, "busy during done", 64'(busy), 64'd1);
        @(negedge clk);
        check(!done && !busy, 9, "done/busy released", {62'd0, done, busy}, 64'd0);
        if (req != 0) ; // tag carried by caller
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog expired: actual hung expected finish");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [31:0] r1;
        logic [31:0] r2;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done, 1, "reset flags", {62'd0, busy, done}, 64'd0);
        check(crc_out == 32'h0, 1, "reset crc_out", 64'(crc_out), 64'd0);
        rst_n = 1'b1;

        // vector table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            run_op(V_POLY[i], V_ACC[i], V_DATA[i], V_CNT[i], V_REQ[i], r);
            check(r == V_EXP[i], V_REQ[i], "table result", 64'(r), 64'(V_EXP[i]));
        end

        // R8: chained CRC-32 over "123456789"
        run_op(1'b0, 64'hFFFF_FFFF, 64'h3837_3635_3433_3231, 4'd8, 8, r1);
        run_op(1'b0, {32'h0, r1}, 64'h39, 4'd1, 8, r2);
        check((r2 ^ 32'hFFFF_FFFF) == 32'hCBF43926, 8, "crc32 check value",
              64'(r2 ^ 32'hFFFF_FFFF), 64'hCBF43926);

        // R8: chained CRC-32C over "123456789"
        run_op(1'b1, 64'hFFFF_FFFF, 64'h3837_3635_3433_3231, 4'd8, 8, r1);
        run_op(1'b1, {32'h0, r1}, 64'h39, 4'd1, 8, r2);
        check((r2 ^ 32'hFFFF_FFFF) == 32'hE3069283, 8, "crc32c check value",
              64'(r2 ^ 32'hFFFF_FFFF), 64'hE3069283);

        // R11: result held while idle and inputs wander
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            poly_sel = ~poly_sel; acc_in = {2{32'h1234_5678 + k}};
            data_in = {8{8'(k)}}; nbytes = 4'(k);
            check(crc_out == r2 && !done, 11, "idle hold", 64'(crc_out), 64'(r2));
        end

        // R10: start pulse mid-operation is ignored
        @(negedge clk);
        poly_sel = 1'b0; acc_in = 64'h0; data_in = 64'h0100_0000_0000_0000;
        nbytes = 4'd8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        poly_sel = 1'b1; acc_in = 64'hFFFF_FFFF; data_in = 64'h5A; nbytes = 4'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int waited;
            waited = 2;
            while (!done && waited < 20) begin
                @(negedge clk);
                waited++;
            end
            check(waited == 8, 10, "latency with ignored start", 64'(waited), 64'd8);
            check(crc_out == 32'h77073096, 10, "result with ignored start",
                  64'(crc_out), 64'h77073096);
        end
        @(negedge clk);
        check(!busy, 10, "no restart from ignored start", 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        check(crc_out == 32'h77073096 && !busy, 11, "hold after ignored start",
              64'(crc_out), 64'h77073096);

        finish_run();
    end
endmodule